// File: doc/BRIEF.md
# Three-Level Interrupt Entry Arbiter

This block decides when a single-threaded processor core may branch into one of its three interrupt service levels. Each level has a 4-bit selector that picks one line out of a 16-wide event vector. A rising edge on the chosen line makes that level pending. A pending level is turned into an injected call only when the instruction stream allows it. Entry is held off while a repeat loop is running, while an operand-extension prefix waits for the instruction it extends, while a queue or alternate-operand qualifier is executing, and while software has raised its stall gate.

Level 1 beats level 2, and level 2 beats level 3. A level that is being serviced holds off itself and every lower level until its return strobe arrives. A higher level may still pre-empt it. When the core sits in a wait-for-interrupt instruction, a parameter selects how the release is handled. In one variant the instruction already in the pipe completes before the call. In the other that instruction is flushed in the same cycle as the call, so the return address points back at it.

A 35-bit status word reports the following:
- the per-level states;
- the three selectors;
- the stall gate;
- the event flags as last sampled.

Top module: `irq_entry_arbiter`

## Requirements
- R1: A rising edge on the event flag chosen by a level's selector makes that level pending. The level's status field reads 2'b10 (waiting) after the clock edge that sampled the edge.
- R2: A pending level that is not held off is granted at the next clock edge. After that edge `inject_o` pulses for one cycle with `inject_lvl_o` = 1, 2 or 3, and the level's status field reads 2'b11 (executing) until its return strobe.
- R3: When several eligible levels are pending at the same edge, level 1 is granted before level 2, and level 2 before level 3.
- R4: No level is granted while `loop_busy_i` is high.
- R5: No level is granted while `pfx_s_wait_i` or `pfx_d_wait_i` is high.
- R6: No level is granted while `qual_busy_i` is high.
- R7: A `stall_cmd_i` strobe sets the stall gate, which blocks every grant until an `allow_cmd_i` strobe clears it. If both strobes arrive in the same cycle, the stall wins. The gate is reported in status bit 16.
- R8: An executing level blocks grants to itself and to all lower-priority levels until its bit of `ret_i` pulses (bit 0 is level 1). A higher-priority pending level is still granted and pre-empts it.
- R9: An event that fires again while its level executes makes the level pending again. The level is granted once more after its return.
- R10: The status word is laid out as: level 3 state [34:33], level 2 state [32:31], level 1 state [30:29], level 3 selector [28:25], level 2 selector [24:21], level 1 selector [20:17], stall gate [16], event flags [15:0]. A state code of 0x means inactive.
- R11: With `WAKE_FLUSH`=0 and `wait_i` high at the grant, `release_o` pulses one cycle with `inject_o` low. `inject_o` follows in the next cycle with `flush_o` low.
- R12: With `WAKE_FLUSH`=1 and `wait_i` high at the grant, `release_o`, `inject_o` and `flush_o` pulse together in one cycle. `flush_o` never rises without a wake.
- R13: Status bits [15:0] equal the event flags sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_flags_i | input | 16 | Event flag vector |
| lvl1_sel_i | input | 4 | Event selector of level 1 |
| lvl2_sel_i | input | 4 | Event selector of level 2 |
| lvl3_sel_i | input | 4 | Event selector of level 3 |
| loop_busy_i | input | 1 | Repeat loop executing or active |
| pfx_s_wait_i | input | 1 | Source-operand extension prefix pending |
| pfx_d_wait_i | input | 1 | Destination-operand extension prefix pending |
| qual_busy_i | input | 1 | Queue or alternate-operand qualifier executing |
| stall_cmd_i | input | 1 | Software stall strobe |
| allow_cmd_i | input | 1 | Software allow strobe |
| ret_i | input | 3 | Return-from-interrupt strobes, bit 0 is level 1 |
| wait_i | input | 1 | Core is parked in a wait-for-interrupt instruction |
| inject_o | output | 1 | Inject the interrupt call this cycle |
| inject_lvl_o | output | 2 | Granted level (1..3), valid with inject_o |
| release_o | output | 1 | Wait-for-interrupt instruction is released |
| flush_o | output | 1 | Cancel the in-pipe instruction and hold the program counter |
| status_o | output | 35 | Packed status word |

## Verification
The bench builds two copies side by side, one with `WAKE_FLUSH`=0 and one with `WAKE_FLUSH`=1, and feeds both the same stimulus. With `wait_i` low the two copies must behave identically, so every priority, blocking and nesting check applies to both of them. With `wait_i` high they must differ by exactly one cycle and by the flush pulse, which makes both wake orderings observable at the ports in a single run.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned NUM_LVL = 3;

  typedef enum logic [1:0] {
    LVL_IDLE = 2'b00,
    LVL_WAIT = 2'b10,
    LVL_EXEC = 2'b11
  } lvl_state_e;

  // Executing dominates waiting in the reported code.
  function automatic lvl_state_e lvl_state(input logic pend, input logic act);
    if (act) return LVL_EXEC;
    if (pend) return LVL_WAIT;
    return LVL_IDLE;
  endfunction

endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture #(
  parameter int unsigned EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] rise_o,
  output logic [EVT_W-1:0] trap_o
);

  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] evt_d;

  always_comb begin
    evt_d = evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_d;
    end
  end

  assign rise_o = evt_i & ~evt_q;
  assign trap_o = evt_q;

endmodule

// File: rtl/irq_level_slot.sv
module irq_level_slot #(
  parameter int unsigned SEL_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] rise_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  grant_i,
  input  logic                  ret_i,
  output logic                  pending_o,
  output logic                  active_o,
  output logic [1:0]            state_o
);
  import irq_arb_pkg::*;

  logic hit;
  logic upd_en;
  logic pend_q, pend_d;
  logic act_q, act_d;

  assign hit    = rise_i[sel_i];
  assign upd_en = hit | grant_i | ret_i;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (grant_i) pend_d = 1'b0;
    if (hit)     pend_d = 1'b1;   // a fresh event re-arms even on its own grant
    if (ret_i)   act_d  = 1'b0;
    if (grant_i) act_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pending_o = pend_q;
  assign active_o  = act_q;
  assign state_o   = lvl_state(pend_q, act_q);

  // R2
  grant_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> (pend_q && !act_q));

  // R8
  exec_ends_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(ret_i));

  // R1
  event_arms_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);

endmodule

// File: rtl/irq_entry_gate.sv
module irq_entry_gate #(
  parameter int unsigned NUM_LVL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] pending_i,
  input  logic [NUM_LVL-1:0] active_i,
  input  logic               loop_busy_i,
  input  logic               pfx_s_i,
  input  logic               pfx_d_i,
  input  logic               qual_i,
  input  logic               seq_busy_i,
  input  logic               stall_cmd_i,
  input  logic               allow_cmd_i,
  output logic [NUM_LVL-1:0] grant_o,
  output logic               stall_o
);

  logic stall_q, stall_d, stall_en;
  logic blocked;
  logic [NUM_LVL-1:0] elig;
  logic [NUM_LVL-1:0] pick;

  assign stall_en = stall_cmd_i | allow_cmd_i;

  always_comb begin
    stall_d = stall_q;
    if (allow_cmd_i) stall_d = 1'b0;
    if (stall_cmd_i) stall_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
    end else if (stall_en) begin
      stall_q <= stall_d;
    end
  end

  assign blocked = loop_busy_i | pfx_s_i | pfx_d_i | qual_i | stall_q | seq_busy_i;

  // Index 0 is the highest priority level.
  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    assign elig[k] = pending_i[k] & ~(|active_i[k:0]);
    if (k == 0) begin : g_top
      assign pick[k] = elig[k];
    end else begin : g_low
      assign pick[k] = elig[k] & ~(|elig[k-1:0]);
    end
  end

  assign grant_o = blocked ? '0 : pick;
  assign stall_o = stall_q;

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R7
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (grant_o == '0));

  // R7
  stall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cmd_i |=> stall_q);

endmodule

// File: rtl/irq_inject_seq.sv
module irq_inject_seq #(
  parameter int unsigned NUM_LVL    = 3,
  parameter bit          WAKE_FLUSH = 1'b0,
  localparam int unsigned LW        = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] grant_i,
  input  logic               wait_i,
  output logic               inject_o,
  output logic [LW-1:0]      level_o,
  output logic               release_o,
  output logic               flush_o,
  output logic               busy_o
);

  logic          grant_any;
  logic [LW-1:0] code;
  logic          wake_defer;
  logic          wake_flush;
  logic          inj_q, inj_d;
  logic          rel_q, rel_d;
  logic          fl_q, fl_d;
  logic          def_q, def_d;
  logic [LW-1:0] lvl_q, lvl_d;

  assign grant_any = |grant_i;

  always_comb begin
    code = '0;
    for (int k = NUM_LVL - 1; k >= 0; k--) begin
      if (grant_i[k]) code = LW'(k + 1);
    end
  end

  if (WAKE_FLUSH) begin : g_flush
    assign wake_defer = 1'b0;
    assign wake_flush = wait_i & grant_any;
  end else begin : g_defer
    assign wake_defer = wait_i & grant_any;
    assign wake_flush = 1'b0;
  end

  always_comb begin
    inj_d = def_q;
    rel_d = 1'b0;
    fl_d  = 1'b0;
    def_d = 1'b0;
    lvl_d = lvl_q;
    if (grant_any) begin
      lvl_d = code;
      rel_d = wait_i;
      def_d = wake_defer;
      inj_d = ~wake_defer;
      fl_d  = wake_flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q <= 1'b0;
      rel_q <= 1'b0;
      fl_q  <= 1'b0;
      def_q <= 1'b0;
    end else begin
      inj_q <= inj_d;
      rel_q <= rel_d;
      fl_q  <= fl_d;
      def_q <= def_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (grant_any) begin
      lvl_q <= lvl_d;
    end
  end

  assign inject_o  = inj_q;
  assign level_o   = lvl_q;
  assign release_o = rel_q;
  assign flush_o   = fl_q;
  assign busy_o    = def_q;

  // R12
  flush_only_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q |-> (inj_q && rel_q));

  // R11
  deferred_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && !inj_q) |=> (inj_q && !fl_q));

  // R2
  inject_has_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_q |-> (lvl_q != '0));

endmodule

// File: rtl/irq_entry_arbiter.sv
module irq_entry_arbiter #(
  parameter int unsigned SEL_W      = 4,
  parameter bit          WAKE_FLUSH = 1'b0,
  localparam int unsigned NL        = irq_arb_pkg::NUM_LVL,
  localparam int unsigned EVT_W     = 1 << SEL_W,
  localparam int unsigned LW        = $clog2(NL + 1),
  localparam int unsigned STAT_W    = 2 * NL + NL * SEL_W + 1 + EVT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_flags_i,
  input  logic [SEL_W-1:0]  lvl1_sel_i,
  input  logic [SEL_W-1:0]  lvl2_sel_i,
  input  logic [SEL_W-1:0]  lvl3_sel_i,
  input  logic              loop_busy_i,
  input  logic              pfx_s_wait_i,
  input  logic              pfx_d_wait_i,
  input  logic              qual_busy_i,
  input  logic              stall_cmd_i,
  input  logic              allow_cmd_i,
  input  logic [NL-1:0]     ret_i,
  input  logic              wait_i,
  output logic              inject_o,
  output logic [LW-1:0]     inject_lvl_o,
  output logic              release_o,
  output logic              flush_o,
  output logic [STAT_W-1:0] status_o
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic [EVT_W-1:0] rise, trap;
  logic [SEL_W-1:0] sel [NL];
  logic [NL-1:0]    pending, active, grant;
  logic [1:0]       st [NL];
  logic             stall, seq_busy;

  assign sel[0] = lvl1_sel_i;
  assign sel[1] = lvl2_sel_i;
  assign sel[2] = lvl3_sel_i;

  irq_evt_capture #(.EVT_W(EVT_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .evt_i  (evt_flags_i),
    .rise_o (rise),
    .trap_o (trap)
  );

  for (genvar k = 0; k < NL; k++) begin : g_slot
    irq_level_slot #(.SEL_W(SEL_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .rise_i    (rise),
      .sel_i     (sel[k]),
      .grant_i   (grant[k]),
      .ret_i     (ret_i[k]),
      .pending_o (pending[k]),
      .active_o  (active[k]),
      .state_o   (st[k])
    );
  end

  irq_entry_gate #(.NUM_LVL(NL)) u_gate (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pending_i   (pending),
    .active_i    (active),
    .loop_busy_i (loop_busy_i),
    .pfx_s_i     (pfx_s_wait_i),
    .pfx_d_i     (pfx_d_wait_i),
    .qual_i      (qual_busy_i),
    .seq_busy_i  (seq_busy),
    .stall_cmd_i (stall_cmd_i),
    .allow_cmd_i (allow_cmd_i),
    .grant_o     (grant),
    .stall_o     (stall)
  );

  irq_inject_seq #(.NUM_LVL(NL), .WAKE_FLUSH(WAKE_FLUSH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .grant_i   (grant),
    .wait_i    (wait_i),
    .inject_o  (inject_o),
    .level_o   (inject_lvl_o),
    .release_o (release_o),
    .flush_o   (flush_o),
    .busy_o    (seq_busy)
  );

  assign status_o = {st[2], st[1], st[0], sel[2], sel[1], sel[0], stall, trap};

endmodule

// File: tb/irq_entry_arbiter_bench.sv
`timescale 1ns/1ps
module irq_entry_arbiter_bench;

  localparam int WD_LIMIT = 20000;
  localparam logic [3:0] S1 = 4'd2, S2 = 4'd5, S3 = 4'd9;
  // {fire mask [7:5] (bit0 = level 1), blocker kind [4:2], expected first level [1:0]}
  // kinds: 0 loop, 1 source prefix, 2 destination prefix, 3 qualifier, 4 stall gate
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{
    {3'b111, 3'd0, 2'd1},
    {3'b110, 3'd1, 2'd2},
    {3'b100, 3'd2, 2'd3},
    {3'b101, 3'd3, 2'd1},
    {3'b110, 3'd4, 2'd2},
    {3'b011, 3'd0, 2'd1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [15:0] evt;
  logic        loop_b, pfx_s, pfx_d, qual, stall_c, allow_c, wt;
  logic [2:0]  ret;
  logic        inj_a, rel_a, fl_a, inj_b, rel_b, fl_b;
  logic [1:0]  lvl_a, lvl_b;
  logic [34:0] st_a, st_b;

  irq_entry_arbiter #(.WAKE_FLUSH(1'b0)) u_irq_entry_arbiter (
    .clk(clk), .rst_n(rst_n), .evt_flags_i(evt),
    .lvl1_sel_i(S1), .lvl2_sel_i(S2), .lvl3_sel_i(S3),
    .loop_busy_i(loop_b), .pfx_s_wait_i(pfx_s), .pfx_d_wait_i(pfx_d),
    .qual_busy_i(qual), .stall_cmd_i(stall_c), .allow_cmd_i(allow_c),
    .ret_i(ret), .wait_i(wt), .inject_o(inj_a), .inject_lvl_o(lvl_a),
    .release_o(rel_a), .flush_o(fl_a), .status_o(st_a));

  irq_entry_arbiter #(.WAKE_FLUSH(1'b1)) u_irq_entry_arbiter_flush (
    .clk(clk), .rst_n(rst_n), .evt_flags_i(evt),
    .lvl1_sel_i(S1), .lvl2_sel_i(S2), .lvl3_sel_i(S3),
    .loop_busy_i(loop_b), .pfx_s_wait_i(pfx_s), .pfx_d_wait_i(pfx_d),
    .qual_busy_i(qual), .stall_cmd_i(stall_c), .allow_cmd_i(allow_c),
    .ret_i(ret), .wait_i(wt), .inject_o(inj_b), .inject_lvl_o(lvl_b),
    .release_o(rel_b), .flush_o(fl_b), .status_o(st_b));

  int checks = 0;
  int errors = 0;
  int cnt_a, cnt_b;
  logic [1:0] last_a, last_b;
  int cycles = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cnt_a = 0; cnt_b = 0; last_a = 2'd0; last_b = 2'd0;
    end else begin
      if (inj_a) begin cnt_a = cnt_a + 1; last_a = lvl_a; end
      if (inj_b) begin cnt_b = cnt_b + 1; last_b = lvl_b; end
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] evt_of(input logic [2:0] m);
    logic [15:0] v = '0;
    if (m[0]) v[S1] = 1'b1;
    if (m[1]) v[S2] = 1'b1;
    if (m[2]) v[S3] = 1'b1;
    return v;
  endfunction

  function automatic logic [1:0] top_lvl(input logic [2:0] m);
    if (m[0]) return 2'd1;
    if (m[1]) return 2'd2;
    if (m[2]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt = '0; loop_b = 0; pfx_s = 0; pfx_d = 0; qual = 0;
    stall_c = 0; allow_c = 0; ret = '0; wt = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic fire(input logic [2:0] m);
    evt = evt_of(m);
    cyc(1);
    evt = '0;
  endtask

  task automatic ret_pulse(input logic [1:0] l);
    ret = '0;
    ret[l-1] = 1'b1;
    cyc(1);
    ret = '0;
  endtask

  task automatic set_block(input logic [2:0] kind, input bit on);
    case (kind)
      3'd0: loop_b = on;
      3'd1: pfx_s = on;
      3'd2: pfx_d = on;
      3'd3: qual = on;
      default: begin
        if (on) stall_c = 1'b1; else allow_c = 1'b1;
        cyc(1);
        stall_c = 1'b0; allow_c = 1'b0;
      end
    endcase
  endtask

  function automatic string blk_req(input logic [2:0] kind);
    case (kind)
      3'd0: return "R4 loop block";
      3'd1: return "R5 source prefix block";
      3'd2: return "R5 destination prefix block";
      3'd3: return "R6 qualifier block";
      default: return "R7 stall gate";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    do_reset();

    // R10 reset image of the status word
    chk(st_a == {6'b0, S3, S2, S1, 1'b0, 16'h0}, "R10 reset status",
        st_a, {6'b0, S3, S2, S1, 1'b0, 16'h0});
    chk(!inj_a && !inj_b && !fl_b, "R2 no inject after reset", inj_a, 0);

    // Table: blocker holds entry, release gives the priority winner
    for (int v = 0; v < NV; v++) begin
      logic [2:0] m, kind, rest;
      logic [1:0] ex;
      m = VEC[v][7:5]; kind = VEC[v][4:2]; ex = VEC[v][1:0];
      do_reset();
      set_block(kind, 1'b1);
      fire(m);
      cyc(3);
      chk(cnt_a == 0 && cnt_b == 0, blk_req(kind), cnt_a, 0);
      chk(st_a[30:29] == (m[0] ? 2'b10 : 2'b00) && st_a[32:31] == (m[1] ? 2'b10 : 2'b00)
          && st_a[34:33] == (m[2] ? 2'b10 : 2'b00), "R1 waiting state", st_a[34:29], m);
      if (kind == 3'd4) chk(st_a[16] == 1'b1, "R7 stall bit", st_a[16], 1);
      set_block(kind, 1'b0);
      cyc(4);
      chk(cnt_a == 1 && last_a == ex && cnt_b == 1 && last_b == ex,
          "R3 priority winner", last_a, ex);
      rest = m;
      rest[ex-1] = 1'b0;
      ret_pulse(ex);
      cyc(3);
      chk(cnt_a == (rest != 0 ? 2 : 1) && (rest == 0 || last_a == top_lvl(rest)),
          "R8 next level after return", last_a, top_lvl(rest));
    end

    // R8 pre-emption and hold-off by an executing level
    do_reset();
    fire(3'b100);
    cyc(3);
    chk(cnt_a == 1 && last_a == 2'd3 && st_a[34:33] == 2'b11, "R2 level 3 entered", last_a, 3);
    chk(!fl_b && !rel_b, "R12 no flush without wake", fl_b, 0);
    fire(3'b001);
    cyc(3);
    chk(cnt_a == 2 && last_a == 2'd1, "R8 level 1 pre-empts level 3", last_a, 1);
    fire(3'b010);
    cyc(3);
    chk(cnt_a == 2 && st_a[32:31] == 2'b10, "R8 level 2 held by executing level 1", cnt_a, 2);
    ret_pulse(2'd1);
    cyc(3);
    chk(cnt_a == 3 && last_a == 2'd2, "R8 level 2 after level 1 returns", last_a, 2);

    // R9 re-arm during service
    fire(3'b010);
    cyc(3);
    chk(cnt_a == 3 && st_a[32:31] == 2'b11, "R9 no re-entry while executing", cnt_a, 3);
    ret_pulse(2'd2);
    cyc(3);
    chk(cnt_a == 4 && last_a == 2'd2 && st_a[34:33] == 2'b11, "R9 re-armed level serviced",
        cnt_a, 4);

    // R11 / R12 wake orderings
    do_reset();
    wt = 1'b1;
    evt = evt_of(3'b001);
    cyc(1);
    evt = '0;
    chk(!inj_a && !rel_a && !inj_b && !rel_b, "R11 nothing yet", rel_a, 0);
    cyc(1);
    chk(rel_a && !inj_a && !fl_a, "R11 release before inject", {rel_a, inj_a, fl_a}, 3'b100);
    chk(rel_b && inj_b && fl_b && lvl_b == 2'd1, "R12 release inject flush together",
        {rel_b, inj_b, fl_b}, 3'b111);
    cyc(1);
    chk(inj_a && !fl_a && !rel_a && lvl_a == 2'd1, "R11 deferred inject",
        {rel_a, inj_a, fl_a}, 3'b010);
    chk(!inj_b && !fl_b, "R12 single pulse", inj_b, 0);
    wt = 1'b0;

    // R7 simultaneous stall and allow
    do_reset();
    stall_c = 1'b1; allow_c = 1'b1;
    cyc(1);
    stall_c = 1'b0; allow_c = 1'b0;
    cyc(1);
    chk(st_a[16] == 1'b1, "R7 stall wins over allow", st_a[16], 1);
    fire(3'b001);
    cyc(3);
    chk(cnt_a == 0, "R7 stall gate blocks", cnt_a, 0);

    // R13 event flag echo
    do_reset();
    evt = 16'hA5C3;
    cyc(1);
    chk(st_a[15:0] == 16'hA5C3, "R13 flags sampled", st_a[15:0], 16'hA5C3);
    evt = 16'h0;
    cyc(1);
    chk(st_a[15:0] == 16'h0 && cnt_a == 0, "R13 flags cleared", st_a[15:0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule